// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a host register interface and the bit-level engine of an I2C master. The host writes one combined data/command word. If bit 8 is set, the word asks the engine to read a byte. If bit 8 is clear, the word carries a byte to transmit. These entries go into a transmit command queue, and the bus engine drains that queue in order through a valid/pop pair. Bytes the engine receives are pushed into a separate receive queue, and the host pops them one at a time.

Both queues report their current fill. A configurable low-water mark drives a transmit-needs-data status, and a configurable high-water mark drives a receive-has-data status. Three sticky error flags record a write into a full command queue, a read from an empty receive queue, and a byte arriving at a full receive queue. A transfer abort empties both queues at once. A one-bit enable register gates the block: while it reads 0, both queues are held empty and new traffic is discarded.

Top module: `i2cm_cmd_queue`

## Requirements
- R1: A host write with wr_data[8]=1 queues a read command, stored and presented on cmd_entry as 9'h100 (low 8 bits forced to zero).
- R2: A host write with wr_data[8]=0 queues {1'b0, wr_data[7:0]}. cmd_valid is high when the block is enabled and the queue is not empty, cmd_entry shows the oldest entry, and cmd_pop removes it, so entries leave in write order.
- R3: rd_data shows the oldest received byte combinationally. rd_en removes it at the next clock edge, so bytes leave in arrival order.
- R4: tx_level and rx_level equal the number of entries held (0 to DEPTH). A push and a pop in the same cycle leave the level unchanged.
- R5: tx_empty_st is 1 exactly when the block is enabled and tx_level <= tx_thresh.
- R6: rx_full_st is 1 exactly when the block is enabled and rx_level > rx_thresh, so a threshold of 0 asserts it with one byte held.
- R7: abort empties both queues by the next cycle and takes priority over any push or pop in the same cycle.
- R8: en_wr loads en_wdata into the enable register, en_state returns its value, and it resets to 0.
- R9: While en_state is 0, both levels are 0 from the next cycle on. Host writes, cmd_pop and rx_push have no effect and set no overflow flag.
- R10: A host write while tx_level equals DEPTH (and enabled, no abort) is dropped and sets tx_over.
- R11: rd_en while rx_level is 0 returns rd_data = 0 and sets rx_under.
- R12: rx_push while rx_level equals DEPTH (and enabled, no abort) is dropped and sets rx_over.
- R13: The three flags are sticky until a flag_clr cycle. If a flag is set and cleared in the same cycle, the set wins.
- R14: After reset, levels, statuses, flags, cmd_valid and en_state are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 1 | Value written to the enable register |
| en_state | output | 1 | Current enable register value |
| wr_en | input | 1 | Host write to the data/command word |
| wr_data | input | 9 | Bit 8 = read request, bits 7:0 = byte to send |
| rd_en | input | 1 | Host read, pops one received byte |
| rd_data | output | 8 | Oldest received byte, 0 when empty |
| tx_thresh | input | clog2(DEPTH+1) | Transmit low-water mark |
| rx_thresh | input | clog2(DEPTH+1) | Receive high-water mark |
| tx_level | output | clog2(DEPTH+1) | Command queue fill |
| rx_level | output | clog2(DEPTH+1) | Receive queue fill |
| tx_empty_st | output | 1 | Command queue at or below its mark |
| rx_full_st | output | 1 | Receive queue above its mark |
| tx_over | output | 1 | Sticky: write into full command queue |
| rx_under | output | 1 | Sticky: read from empty receive queue |
| rx_over | output | 1 | Sticky: byte lost at full receive queue |
| flag_clr | input | 1 | Clears the three sticky flags |
| abort | input | 1 | Transfer abort, empties both queues |
| cmd_valid | output | 1 | Command entry available to the bus engine |
| cmd_entry | output | 9 | Oldest command entry |
| cmd_pop | input | 1 | Bus engine consumes cmd_entry |
| rx_push | input | 1 | Bus engine delivers a received byte |
| rx_byte | input | 8 | Received byte |

## Verification
The hardest situations to reach are the collisions. One is an abort or a disable landing in the same cycle as a host write, an engine pop and an engine push. Another is a push into a queue that is exactly full while a pop happens in the same cycle. A third is a flag clear coinciding with a new error. Directed sequences first fill each queue to DEPTH and then hold it there while pushes, pops and clears arrive together. A long seeded random phase keeps both queues hovering near full, with occasional aborts and enable changes, so these overlaps recur. Each cycle is compared against a queue model kept in the bench.

// File: rtl/i2cq_pkg.sv
// Shared constants and helpers for the I2C master command/receive queue.
// Assumes a 9-bit host word whose bit 8 marks a read request.
package i2cq_pkg;
    localparam int WORD_W  = 9;
    localparam int BYTE_W  = 8;
    localparam int RD_FLAG = 8;

    // Turn a host word into the entry stored in the command queue.
    function automatic logic [WORD_W-1:0] to_entry(input logic [WORD_W-1:0] w);
        return w[RD_FLAG] ? {1'b1, {BYTE_W{1'b0}}} : {1'b0, w[BYTE_W-1:0]};
    endfunction
endpackage

// File: rtl/cmdq_fifo.sv
// Synchronous FIFO with flush. Pushes into a full queue and pops from an empty
// queue are ignored. Flush takes priority over push and pop.
// Assumes DEPTH >= 2; DEPTH need not be a power of two.
module cmdq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    // Pointer and fill tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC);
    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R4
    level_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push_ok && pop_ok) |=> (count == $past(count)));
endmodule

// File: rtl/cmdq_status.sv
// Threshold statuses and sticky error flags for the queue block.
// Assumes the set events are already qualified by enable and abort.
module cmdq_status #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input  logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input  logic [$clog2(DEPTH+1)-1:0] tx_thresh,
    input  logic [$clog2(DEPTH+1)-1:0] rx_thresh,
    input  logic                       set_tx_over,
    input  logic                       set_rx_under,
    input  logic                       set_rx_over,
    input  logic                       clr,
    output logic                       tx_empty_st,
    output logic                       rx_full_st,
    output logic                       tx_over,
    output logic                       rx_under,
    output logic                       rx_over
);
    // Level comparisons against the two water marks.
    always_comb begin
        tx_empty_st = en && (tx_cnt <= tx_thresh);
        rx_full_st  = en && (rx_cnt > rx_thresh);
    end

    // Sticky flags: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_over  <= 1'b0;
            rx_under <= 1'b0;
            rx_over  <= 1'b0;
        end else begin
            tx_over  <= set_tx_over  || (tx_over  && !clr);
            rx_under <= set_rx_under || (rx_under && !clr);
            rx_over  <= set_rx_over  || (rx_over  && !clr);
        end
    end

    // R13
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_over && !clr) |=> tx_over);
    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rx_over && clr) |=> rx_over);
endmodule

// File: rtl/i2cm_cmd_queue.sv
// Host-side command and receive queueing for an I2C master. One host word
// queues either a byte to send or a read request; the bus engine drains the
// command queue and fills the receive queue. Abort and disable empty both.
// Assumes the bus engine only pops when cmd_valid is high.
module i2cm_cmd_queue
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_wr,
    input  logic                       en_wdata,
    output logic                       en_state,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [BYTE_W-1:0]          rd_data,
    input  logic [$clog2(DEPTH+1)-1:0] tx_thresh,
    input  logic [$clog2(DEPTH+1)-1:0] rx_thresh,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_empty_st,
    output logic                       rx_full_st,
    output logic                       tx_over,
    output logic                       rx_under,
    output logic                       rx_over,
    input  logic                       flag_clr,
    input  logic                       abort,
    output logic                       cmd_valid,
    output logic [WORD_W-1:0]          cmd_entry,
    input  logic                       cmd_pop,
    input  logic                       rx_push,
    input  logic [BYTE_W-1:0]          rx_byte
);
    logic              flush, live;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head;
    logic [BYTE_W-1:0] rx_head;

    // Enable register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_state <= 1'b0;
        else if (en_wr) en_state <= en_wdata;
    end

    // Queue-wide qualifiers.
    always_comb begin
        flush = !en_state || abort;
        live  = en_state && !abort;
    end

    cmdq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(live && wr_en), .din(to_entry(wr_data)),
        .pop(live && cmd_pop), .dout(tx_head),
        .count(tx_level), .full(tx_full), .empty(tx_empty)
    );

    cmdq_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(live && rx_push), .din(rx_byte),
        .pop(rd_en), .dout(rx_head),
        .count(rx_level), .full(rx_full), .empty(rx_empty)
    );

    cmdq_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n), .en(en_state),
        .tx_cnt(tx_level), .rx_cnt(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .set_tx_over(live && wr_en && tx_full),
        .set_rx_under(rd_en && rx_empty),
        .set_rx_over(live && rx_push && rx_full),
        .clr(flag_clr),
        .tx_empty_st(tx_empty_st), .rx_full_st(rx_full_st),
        .tx_over(tx_over), .rx_under(rx_under), .rx_over(rx_over)
    );

    // Output presentation, zeroed when nothing is held.
    always_comb begin
        cmd_valid = en_state && !tx_empty;
        cmd_entry = cmd_valid ? tx_head : '0;
        rd_data   = rx_empty ? '0 : rx_head;
    end

    // R9
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_state |=> (tx_level == '0 && rx_level == '0));
    // R10
    tx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state && !abort && wr_en && tx_level == DEPTH) |=> (tx_over && tx_level == DEPTH - $past(cmd_pop)));
    // R11
    rx_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_level == '0) |-> (rd_data == '0) ##1 rx_under);
    // R12
    rx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state && !abort && rx_push && rx_level == DEPTH) |=> rx_over);
    // R7
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_level == '0 && rx_level == '0 && !cmd_valid));
endmodule

// File: tb/sim_i2cm_cmd_queue.sv
`timescale 1ns/1ps
module sim_i2cm_cmd_queue;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_wr = 0, en_wdata = 0, wr_en = 0, rd_en = 0, flag_clr = 0, abort = 0;
    logic cmd_pop = 0, rx_push = 0;
    logic [8:0] wr_data = '0;
    logic [7:0] rx_byte = '0;
    logic [CW-1:0] tx_thresh = '0, rx_thresh = '0;
    logic en_state, tx_empty_st, rx_full_st, tx_over, rx_under, rx_over, cmd_valid;
    logic [7:0] rd_data;
    logic [8:0] cmd_entry;
    logic [CW-1:0] tx_level, rx_level;

    int checks = 0, errors = 0, cyc = 0;
    logic [8:0] txq[$];
    logic [7:0] rxq[$];
    logic m_en = 0, m_txo = 0, m_rxu = 0, m_rxo = 0;

    always #4 clk = ~clk;

    i2cm_cmd_queue #(.DEPTH(DEPTH)) u0 (.*);

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            summary();
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_entry(input logic [8:0] w);
        return w[8] ? 9'h100 : {1'b0, w[7:0]};
    endfunction

    task automatic idle();
        en_wr = 0; wr_en = 0; rd_en = 0; flag_clr = 0; abort = 0;
        cmd_pop = 0; rx_push = 0;
    endtask

    // Compare every output against the model.
    task automatic compare();
        check("R4 tx_level", tx_level, txq.size());
        check("R4 rx_level", rx_level, rxq.size());
        check("R8 en_state", en_state, m_en);
        check("R5 tx_empty_st", tx_empty_st, m_en && (txq.size() <= tx_thresh));
        check("R6 rx_full_st", rx_full_st, m_en && (rxq.size() > rx_thresh));
        check("R10 tx_over", tx_over, m_txo);
        check("R11 rx_under", rx_under, m_rxu);
        check("R12 rx_over", rx_over, m_rxo);
        check("R2 cmd_valid", cmd_valid, m_en && txq.size() > 0);
        if (m_en && txq.size() > 0)
            check(txq[0][8] ? "R1 cmd_entry" : "R2 cmd_entry", cmd_entry, txq[0]);
    endtask

    // One clock: drive, model, then compare after the edge.
    task automatic tick();
        bit live, flush, txfull, rxfull, rxempty;
        @(negedge clk);
        #1;
        rxempty = (rxq.size() == 0);
        if (rd_en) check(rxempty ? "R11 rd_data" : "R3 rd_data", rd_data, rxempty ? 0 : rxq[0]);
        flush  = !m_en || abort;
        live   = m_en && !abort;
        txfull = (txq.size() == DEPTH);
        rxfull = (rxq.size() == DEPTH);
        m_txo = (live && wr_en && txfull) || (m_txo && !flag_clr);
        m_rxu = (rd_en && rxempty) || (m_rxu && !flag_clr);
        m_rxo = (live && rx_push && rxfull) || (m_rxo && !flag_clr);
        if (flush) begin
            txq.delete(); rxq.delete();
        end else begin
            if (cmd_pop && txq.size() > 0) void'(txq.pop_front());
            if (wr_en && !txfull) txq.push_back(exp_entry(wr_data));
            if (rd_en && !rxempty) void'(rxq.pop_front());
            if (rx_push && !rxfull) rxq.push_back(rx_byte);
        end
        if (en_wr) m_en = en_wdata;
        @(posedge clk);
        #2;
        compare();
        idle();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        // R14 reset state
        check("R14 tx_level", tx_level, 0);
        check("R14 rx_level", rx_level, 0);
        check("R14 en_state", en_state, 0);
        check("R14 flags", {tx_over, rx_under, rx_over, cmd_valid, tx_empty_st, rx_full_st}, 0);
        rst_n = 1'b1;

        // R9 writes while disabled are ignored
        wr_en = 1; wr_data = 9'h0AA; rx_push = 1; rx_byte = 8'h11; tick();
        check("R9 disabled tx", tx_level, 0);
        check("R9 disabled rx", rx_level, 0);
        check("R9 no flags", {tx_over, rx_over}, 0);

        // R8 enable
        en_wr = 1; en_wdata = 1; tick();
        check("R8 enabled", en_state, 1);

        // R1 R2 R10 fill command queue past full
        tx_thresh = 2;
        for (int i = 0; i < DEPTH + 1; i++) begin
            wr_en = 1; wr_data = (i % 3 == 0) ? 9'h1FF : 9'(i + 8'h40); tick();
        end
        check("R10 tx_over set", tx_over, 1);
        check("R10 level at full", tx_level, DEPTH);
        // push+pop at full, overflow again with simultaneous pop
        wr_en = 1; wr_data = 9'h033; cmd_pop = 1; tick();
        for (int i = 0; i < DEPTH; i++) begin cmd_pop = 1; tick(); end

        // R12 R6 fill receive queue, threshold 0
        rx_thresh = 0;
        rx_push = 1; rx_byte = 8'h5A; tick();
        check("R6 rx_full_st at one byte", rx_full_st, 1);
        for (int i = 0; i < DEPTH; i++) begin rx_push = 1; rx_byte = 8'(i * 7 + 3); tick(); end
        check("R12 rx_over set", rx_over, 1);
        // R13 clear and new event in the same cycle
        rx_push = 1; rx_byte = 8'hEE; flag_clr = 1; tick();
        check("R13 set wins", rx_over, 1);
        flag_clr = 1; tick();
        check("R13 cleared", {tx_over, rx_over}, 0);
        // R3 drain, then R11 underflow
        for (int i = 0; i < DEPTH; i++) begin rd_en = 1; tick(); end
        rd_en = 1; tick();
        check("R11 rx_under set", rx_under, 1);

        // R7 abort with concurrent traffic
        for (int i = 0; i < 4; i++) begin wr_en = 1; wr_data = 9'(i); rx_push = 1; rx_byte = 8'(i); tick(); end
        abort = 1; wr_en = 1; wr_data = 9'h077; rx_push = 1; cmd_pop = 1; tick();
        check("R7 tx flushed", tx_level, 0);
        check("R7 rx flushed", rx_level, 0);

        // R9 disable while holding data
        for (int i = 0; i < 3; i++) begin wr_en = 1; wr_data = 9'h100; rx_push = 1; tick(); end
        en_wr = 1; en_wdata = 0; tick();
        wr_en = 1; wr_data = 9'h012; rx_push = 1; tick();
        check("R9 held empty tx", tx_level, 0);
        check("R9 held empty rx", rx_level, 0);
        en_wr = 1; en_wdata = 1; flag_clr = 1; tick();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                tx_thresh = CW'($urandom_range(DEPTH));
                rx_thresh = CW'($urandom_range(DEPTH));
            end
            wr_en    = ($urandom_range(99) < 55);
            wr_data  = 9'($urandom);
            cmd_pop  = ($urandom_range(99) < 40);
            rx_push  = ($urandom_range(99) < 50);
            rx_byte  = 8'($urandom);
            rd_en    = ($urandom_range(99) < 40);
            abort    = ($urandom_range(99) < 2);
            flag_clr = ($urandom_range(99) < 5);
            en_wr    = ($urandom_range(199) == 0);
            en_wdata = ($urandom_range(99) < 70);
            if (!m_en && $urandom_range(9) == 0) begin en_wr = 1; en_wdata = 1; end
            tick();
        end
        summary();
    end
endmodule